// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clocks run in a small microcontroller. It holds a four-bit power-control register. That register carries a CPU-halt bit, an oscillator-stop bit and two software flag bits. From the single oscillator input it derives two gated clocks. One clock feeds the CPU. The other feeds the peripheral group, which is the interrupt, serial and timer logic. It also produces an oscillator run enable. In halt mode only the CPU clock stops. In stop mode the oscillator enable falls, so every derived clock stops, but all stored state is kept.

An enabled interrupt request ends halt mode but has no effect in stop mode. The raw reset pin clears the halt bit at once, without waiting for a clock edge. The pin also forces the oscillator back on. The pin must then stay high for a fixed number of oscillator periods before the block issues its internal reset request. That request clears the whole power-control register. While either low-power mode is active, the two external bus strobes are forced high.

Top module: `lp_clock_ctrl`

## Requirements
- R1: `ctrl_q` bit 0 is the halt bit, bit 1 is the stop bit and bits 3:2 are software flags. A write made while the CPU clock is enabled loads all four bits from `wr_data`. Hardware never changes the flags, except when it clears them on the internal reset.
- R2: While halt is set and stop is clear, `cpu_clk` stays low, while `per_clk` follows `osc_clk` and `osc_run` is high.
- R3: While stop is set and `rst_pin` is low, `osc_run` is low, `cpu_clk` and `per_clk` stay low, and `ctrl_q` keeps its value.
- R4: A write with `wr_data` bits 1 and 0 both set stores stop = 1 and halt = 0.
- R5: When `irq_req` is high at a rising edge while halt is set, halt is clear after that edge and `cpu_clk` resumes from the next cycle.
- R6: `irq_req` has no effect on `ctrl_q` while stop is set.
- R7: A rising `rst_pin` clears the halt bit before any further `osc_clk` edge.
- R8: `core_rst` goes high after `rst_pin` has been sampled high on HOLD_CYCLES consecutive rising edges (default 24). It falls at the first edge that samples the pin low. A pin pulse shorter than that window raises no request, and the count restarts from zero.
- R9: A high `rst_pin` raises `osc_run` at once, even in stop mode. Every rising edge with `core_rst` high clears `ctrl_q` to 0.
- R10: `ale_force` and `psen_force` are high exactly while halt or stop is set.
- R11: Writes are ignored while halt or stop is set.
- R12: The gated clocks are never high while `osc_clk` is low, so no gated pulse is shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high, asynchronous |
| wr_en | input | 1 | Power-control register write strobe |
| wr_data | input | 4 | Write data for the power-control register |
| irq_req | input | 1 | Enabled interrupt request |
| ctrl_q | output | 4 | Power-control register contents |
| cpu_clk | output | 1 | Gated CPU clock |
| per_clk | output | 1 | Gated peripheral clock |
| osc_run | output | 1 | Oscillator run enable |
| core_rst | output | 1 | Internal synchronous reset request |
| ale_force | output | 1 | Address-latch strobe forced high |
| psen_force | output | 1 | Program-store strobe forced high |

## Verification
Any wrong halt or stop state shows up on the gated clocks in the very next high phase of `osc_clk`. It also shows on `ale_force` and `psen_force` right after the edge that produced it. A miscounted hold counter moves the rising edge of `core_rst` by at least one cycle, so it is caught within the 24-edge window. Such a counter can also leave stale register contents one edge later. Ignored writes and ignored interrupts are confirmed by reading `ctrl_q` on the cycle right after the stimulus.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    localparam int CTRL_W   = 4;
    localparam int HALT_POS = 0;
    localparam int STOP_POS = 1;
    localparam int FLAG_LO  = 2;
    localparam int FLAG_W   = CTRL_W - FLAG_LO;

    typedef struct packed {
        logic              stop;
        logic [FLAG_W-1:0] flag;
    } ctl_t;

    localparam int N_GATES = 2;
    localparam int G_CPU   = 0;
    localparam int G_PER   = 1;
endpackage

// File: rtl/lpc_ctrl_reg.sv
module lpc_ctrl_reg
    import lpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_pin,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              irq_req,
    output logic              halt_o,
    output ctl_t              ctl_o
);
    ctl_t ctl_d, ctl_q;
    logic halt_d, halt_q;
    logic cpu_run;

    always_comb begin
        ctl_d   = ctl_q;
        halt_d  = halt_q;
        cpu_run = !halt_q && !ctl_q.stop;
        if (clr) begin
            ctl_d  = '0;
            halt_d = 1'b0;
        end else begin
            if (wr_en && cpu_run) begin
                ctl_d.stop = wr_data[STOP_POS];
                ctl_d.flag = wr_data[FLAG_LO +: FLAG_W];
                // stop wins over halt when both are requested
                halt_d     = wr_data[HALT_POS] & ~wr_data[STOP_POS];
            end
            if (irq_req && halt_q) begin
                halt_d = 1'b0;
            end
        end
    end

    // halt bit: cleared by the pin without a clock edge
    always_ff @(posedge clk or posedge rst_pin) begin
        if (rst_pin) begin
            halt_q <= 1'b0;
        end else begin
            halt_q <= halt_d;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign halt_o = halt_q;
    assign ctl_o  = ctl_q;
endmodule

// File: rtl/lpc_rst_hold.sv
module lpc_rst_hold #(
    parameter int HOLD_CYCLES = 24
) (
    input  logic clk,
    input  logic pin,
    output logic rst_req
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!pin) begin
            cnt_d = '0;
        end else if (cnt_q == HOLD) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign rst_req = (cnt_q == HOLD);
endmodule

// File: rtl/lpc_clk_gate.sv
module lpc_clk_gate (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_l;

    // enable passes only while the clock is low
    always_latch begin
        if (!clk_in) begin
            en_l = en;
        end
    end

    assign clk_out = clk_in & en_l;
endmodule

// File: rtl/lp_clock_ctrl.sv
module lp_clock_ctrl
    import lpc_pkg::*;
#(
    parameter int HOLD_CYCLES = 24
) (
    input  logic              osc_clk,
    input  logic              rst_pin,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              irq_req,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              cpu_clk,
    output logic              per_clk,
    output logic              osc_run,
    output logic              core_rst,
    output logic              ale_force,
    output logic              psen_force
);
    logic               halt;
    ctl_t               ctl;
    logic [N_GATES-1:0] gate_en;
    logic [N_GATES-1:0] gate_clk;
    logic               low_power;

    lpc_rst_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk     (osc_clk),
        .pin     (rst_pin),
        .rst_req (core_rst)
    );

    lpc_ctrl_reg u_reg (
        .clk     (osc_clk),
        .rst_pin (rst_pin),
        .clr     (core_rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .irq_req (irq_req),
        .halt_o  (halt),
        .ctl_o   (ctl)
    );

    assign osc_run          = !ctl.stop || rst_pin;
    assign gate_en[G_CPU]   = !halt && !ctl.stop;
    assign gate_en[G_PER]   = osc_run;

    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        lpc_clk_gate u_gate (
            .clk_in  (osc_clk),
            .en      (gate_en[g]),
            .clk_out (gate_clk[g])
        );
    end

    assign cpu_clk    = gate_clk[G_CPU];
    assign per_clk    = gate_clk[G_PER];
    assign low_power  = halt || ctl.stop;
    assign ale_force  = low_power;
    assign psen_force = low_power;

    always_comb begin
        ctrl_q                       = '0;
        ctrl_q[HALT_POS]             = halt;
        ctrl_q[STOP_POS]             = ctl.stop;
        ctrl_q[FLAG_LO +: FLAG_W]    = ctl.flag;
    end
endmodule

// File: rtl/lp_clock_ctrl_chk.sv
module lp_clock_ctrl_chk (
    input logic       osc_clk,
    input logic       rst_pin,
    input logic       wr_en,
    input logic       irq_req,
    input logic [3:0] ctrl_q,
    input logic       core_rst
);
    p_stop_wins_r4: assert property (@(posedge osc_clk)
        !(ctrl_q[0] && ctrl_q[1]));

    p_irq_ends_halt_r5: assert property (@(posedge osc_clk) disable iff (rst_pin)
        (ctrl_q[0] && irq_req && !core_rst) |=> !ctrl_q[0]);

    p_stop_holds_r6: assert property (@(posedge osc_clk) disable iff (rst_pin)
        (ctrl_q[1] && !core_rst) |=> ctrl_q[1]);

    p_flags_stable_r1: assert property (@(posedge osc_clk) disable iff (rst_pin)
        (!wr_en && !core_rst) |=> $stable(ctrl_q[3:2]));

    p_req_needs_pin_r8: assert property (@(posedge osc_clk)
        core_rst |-> $past(rst_pin));

    p_pin_clears_halt_r7: assert property (@(negedge osc_clk)
        rst_pin |-> !ctrl_q[0]);
endmodule

bind lp_clock_ctrl lp_clock_ctrl_chk u_chk (
    .osc_clk  (osc_clk),
    .rst_pin  (rst_pin),
    .wr_en    (wr_en),
    .irq_req  (irq_req),
    .ctrl_q   (ctrl_q),
    .core_rst (core_rst)
);

// File: tb/test_lp_clock_ctrl.sv
module test_lp_clock_ctrl;
    localparam int HOLD = 24;

    logic       osc_clk = 1'b0;
    logic       rst_pin = 1'b0;
    logic       wr_en   = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic       irq_req = 1'b0;
    logic [3:0] ctrl_q;
    logic       cpu_clk, per_clk, osc_run, core_rst, ale_force, psen_force;

    int checks = 0;
    int errors = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    // behavioural reference state
    bit       m_halt = 0, m_stop = 0;
    bit [1:0] m_flag = 0;
    int       m_cnt  = 0;
    bit       e_cpu, e_per, halt_eff;

    lp_clock_ctrl #(.HOLD_CYCLES(HOLD)) i_lp_clock_ctrl (
        .osc_clk    (osc_clk),
        .rst_pin    (rst_pin),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .irq_req    (irq_req),
        .ctrl_q     (ctrl_q),
        .cpu_clk    (cpu_clk),
        .per_clk    (per_clk),
        .osc_run    (osc_run),
        .core_rst   (core_rst),
        .ale_force  (ale_force),
        .psen_force (psen_force)
    );

    always #5 osc_clk = ~osc_clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // model update and comparison on every edge
    always @(posedge osc_clk) begin
        e_cpu    = !((m_halt && !rst_pin) || m_stop);
        e_per    = !m_stop || rst_pin;
        halt_eff = m_halt && !rst_pin;
        if (m_cnt == HOLD) begin
            m_halt = 0; m_stop = 0; m_flag = 0;
        end else begin
            if (wr_en && !halt_eff && !m_stop) begin
                m_stop = wr_data[1];
                m_halt = wr_data[0] && !wr_data[1];
                m_flag = wr_data[3:2];
            end
            if (irq_req && halt_eff) m_halt = 0;
            if (rst_pin) m_halt = 0;
        end
        m_cnt = rst_pin ? ((m_cnt == HOLD) ? HOLD : m_cnt + 1) : 0;
        #2;
        if (armed) begin
            chk("R1 ctrl_q", ctrl_q, {m_flag, m_stop, m_halt && !rst_pin});
            chk("R2 cpu_clk", cpu_clk, e_cpu);
            chk("R3 per_clk", per_clk, e_per);
            chk("R3 osc_run", osc_run, !m_stop || rst_pin);
            chk("R8 core_rst", core_rst, m_cnt == HOLD);
            chk("R10 ale_force", ale_force, (m_halt && !rst_pin) || m_stop);
            chk("R10 psen_force", psen_force, (m_halt && !rst_pin) || m_stop);
        end
    end

    // gated clocks must be low in every low phase
    always @(negedge osc_clk) begin
        #1;
        if (armed) begin
            chk("R12 cpu_clk low phase", cpu_clk, 1'b0);
            chk("R12 per_clk low phase", per_clk, 1'b0);
        end
    end

    task automatic at_low();
        @(negedge osc_clk);
        #1;
    endtask

    task automatic do_write(input logic [3:0] d);
        at_low();
        wr_en = 1'b1; wr_data = d;
        at_low();
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (2) at_low();
        rst_pin = 1'b1;
        repeat (HOLD + 3) at_low();
        rst_pin = 1'b0;
        repeat (2) at_low();
        armed = 1'b1;
        chk("R9 reset state", ctrl_q, 4'h0);

        do_write(4'b1100);
        chk("R1 flags written", ctrl_q, 4'b1100);
        do_write(4'b0100);
        chk("R1 flags rewritten", ctrl_q, 4'b0100);

        do_write(4'b0101);
        chk("R2 halt entered", ctrl_q, 4'b0101);
        repeat (4) at_low();
        chk("R10 strobe in halt", ale_force, 1'b1);

        do_write(4'b0010);
        chk("R11 write ignored in halt", ctrl_q, 4'b0101);

        at_low();
        irq_req = 1'b1;
        at_low();
        irq_req = 1'b0;
        chk("R5 irq ends halt", ctrl_q, 4'b0100);

        do_write(4'b1011);
        chk("R4 stop wins", ctrl_q, 4'b1010);
        at_low();
        irq_req = 1'b1;
        repeat (2) at_low();
        irq_req = 1'b0;
        chk("R6 irq ignored in stop", ctrl_q, 4'b1010);
        chk("R3 osc off", osc_run, 1'b0);
        do_write(4'b0000);
        chk("R11 write ignored in stop", ctrl_q, 4'b1010);

        at_low();
        rst_pin = 1'b1;
        #1;
        chk("R9 pin restarts osc", osc_run, 1'b1);
        repeat (HOLD + 1) at_low();
        chk("R9 reset clears register", ctrl_q, 4'h0);
        rst_pin = 1'b0;
        repeat (2) at_low();

        do_write(4'b1001);
        chk("R2 halt with flags", ctrl_q, 4'b1001);
        rst_pin = 1'b1;
        #1;
        chk("R7 async halt clear", ctrl_q, 4'b1000);
        repeat (10) at_low();
        rst_pin = 1'b0;
        repeat (2) at_low();
        chk("R8 short pulse no request", core_rst, 1'b0);
        chk("R8 short pulse keeps flags", ctrl_q, 4'b1000);

        rst_pin = 1'b1;
        repeat (HOLD - 1) @(posedge osc_clk);
        #2;
        chk("R8 no request before window", core_rst, 1'b0);
        @(posedge osc_clk);
        #2;
        chk("R8 request at window end", core_rst, 1'b1);
        at_low();
        rst_pin = 1'b0;
        @(posedge osc_clk);
        #2;
        chk("R8 request drops", core_rst, 1'b0);
        repeat (3) at_low();
        finish_run();
    end
endmodule